// File: doc/BRIEF.md
# External Memory Access Timing Generator

This block produces the active-low control strobes for one static memory chip select during a single read or write access. The host raises a request carrying direction, address, byte enables and write data, and holds it until a one-cycle acknowledge comes back. Inside the access, a cycle counter starts at zero and drives three timing windows: chip select, read strobe and write strobe. Each window has its own setup length and pulse length, and the chip-select window takes separate values for reads and for writes. The access always ends when the counter reaches the total cycle length for its direction.

The external device can stretch an access through an active-low wait input. Three wait behaviours are available: ignore the input, freeze the whole sequence while the input is low, or hold the controlling strobe at the last cycle of its pulse until the device is ready. Two byte-lane styles are offered. In one, lane selects follow the chip-select window. In the other, each lane has its own write strobe. The data bus can be 8 or 16 bits wide. After a read, a data-float interval keeps the next access off the bus for a programmed number of cycles. An optional skip bit lets a following read start without that wait.

Top module: `ext_mem_timing`

## Requirements
- R1: While reset is applied and after it is released, every strobe, lane select and lane write strobe is high, and the acknowledge and the data drive enable are low.
- R2: With access cycle counter k (0 in the first cycle after acceptance), `mem_cs_n` is low exactly when setup <= k < setup + pulse, using the chip-select read or write pair that matches the access direction. A pulse of zero keeps it high.
- R3: `mem_rd_n` (reads only) and `mem_we_n` (writes only) follow the same window rule with their own setup and pulse. A setup of zero asserts the strobe in cycle 0. A window reaching past the cycle length is cut off at the end of the access.
- R4: An access lasts exactly the programmed cycle length for its direction, and a length of 0 counts as 1. `req_ack` is high for exactly one cycle, the first cycle after the last access cycle, and every strobe is high in that cycle.
- R5: `rd_data` holds the `mem_din` value present in the last low cycle of `mem_rd_n`, which is sampled on the strobe's rising edge. On an 8-bit bus its upper byte is zero.
- R6: With wait mode 2, every cycle in which `mem_wait_n` is low at a clock edge repeats the current access cycle with all outputs unchanged. The access resumes from that point afterwards.
- R7: With wait mode 3, `mem_wait_n` is looked at only in the last pulse cycle of the controlling strobe (read strobe for reads, write strobe for writes). While it is low there, that cycle repeats. Elsewhere it has no effect.
- R8: With wait mode 0 or 1, `mem_wait_n` has no effect on the strobe timing.
- R9: With `cfg_byte_write`=0, lane select bit i is low whenever `mem_cs_n` is low and byte enable bit i is set. `mem_we_n` carries the write window, and the lane write strobes stay high.
- R10: With `cfg_byte_write`=1, the lane selects and `mem_we_n` stay high, and lane write strobe i is low inside the write window when byte enable bit i is set. Reads use only `mem_cs_n` and `mem_rd_n`.
- R11: With `cfg_wide`=0 (8-bit bus), lane 1 select and lane 1 write strobe stay high, and `mem_dout` carries the low write byte with zero above it. With `cfg_wide`=1, both lanes are used.
- R12: `mem_drive_en` is high in every cycle of a write access and in no other cycle, and `mem_dout` then holds the request's write data.
- R13: After a read ends, the next access starts no earlier than max(2, F+1) cycles after the last read cycle, where F is `cfg_float_cycles`. With `cfg_float_skip`=1, a following read waits only the 2-cycle minimum and a write still waits the full interval. After a write, the minimum is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_be | input | LANES | Byte enables |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DW | Captured read data |
| cfg_cs_rd_setup | input | SW | Chip-select setup, reads |
| cfg_cs_rd_pulse | input | PW | Chip-select pulse, reads |
| cfg_rd_setup | input | SW | Read strobe setup |
| cfg_rd_pulse | input | PW | Read strobe pulse |
| cfg_rd_cycle | input | CW | Read total cycle length |
| cfg_cs_wr_setup | input | SW | Chip-select setup, writes |
| cfg_cs_wr_pulse | input | PW | Chip-select pulse, writes |
| cfg_wr_setup | input | SW | Write strobe setup |
| cfg_wr_pulse | input | PW | Write strobe pulse |
| cfg_wr_cycle | input | CW | Write total cycle length |
| cfg_wait_mode | input | 2 | 0/1 ignore, 2 freeze, 3 ready |
| cfg_byte_write | input | 1 | 0 lane selects, 1 per-lane write strobes |
| cfg_wide | input | 1 | 0 8-bit bus, 1 16-bit bus |
| cfg_float_cycles | input | FW | Idle cycles after a read |
| cfg_float_skip | input | 1 | Let a read bypass the float interval |
| mem_addr | output | AW | Address held for the access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lane_n | output | LANES | Byte lane selects, active low |
| mem_lane_we_n | output | LANES | Per-lane write strobes, active low |
| mem_wait_n | input | 1 | Device wait request, active low |
| mem_dout | output | DW | Write data toward the device |
| mem_drive_en | output | 1 | Write data drive enable |
| mem_din | input | DW | Read data from the device |

## Verification
The request is sampled at a rising edge, and the strobes for counter value 0 appear in the very next cycle because they are registered from the next-state decode. The bench therefore drives at falling edges and reads the outputs for cycle k at the k-th falling edge after acceptance. A lockstep model keeps its own k and advances it only when the wait rule in force would not repeat the cycle. The acknowledge and the captured read data are checked one falling edge after the last access cycle. The float gap is counted in falling edges from the acknowledge to the first low chip select of the next access, which comes to max(2, F+1).

// File: rtl/emt_pkg.sv
package emt_pkg;
  typedef enum logic [1:0] {
    WAIT_OFF    = 2'd0,
    WAIT_UNUSED = 2'd1,
    WAIT_FREEZE = 2'd2,
    WAIT_READY  = 2'd3
  } wait_mode_e;

  localparam int STROBE_CS = 0;
  localparam int STROBE_RD = 1;
  localparam int STROBE_WR = 2;
  localparam int NUM_STROBES = 3;
endpackage

// File: rtl/emt_window.sv
module emt_window #(
  parameter int SW = 6,
  parameter int PW = 7,
  parameter int CW = 9
) (
  input  logic [CW-1:0] cnt,
  input  logic [SW-1:0] setup,
  input  logic [PW-1:0] pulse,
  input  logic [CW-1:0] last,
  output logic          active,
  output logic          at_end
);
  localparam int MX = (SW > PW) ? SW : PW;
  localparam int EW = ((CW > MX) ? CW : MX) + 1;

  logic [EW-1:0] stop_w;
  logic [EW-1:0] cur_w;

  always_comb begin
    stop_w = EW'(setup) + EW'(pulse);
    cur_w  = EW'(cnt);
    active = (pulse != '0) && (cur_w >= EW'(setup)) && (cur_w < stop_w);
    at_end = active && (((cur_w + EW'(1)) == stop_w) || (cnt == last));
  end
endmodule

// File: rtl/emt_lanes.sv
module emt_lanes #(
  parameter int LANES = 2
) (
  input  logic             act,
  input  logic             is_wr,
  input  logic             cs_on,
  input  logic             rd_on,
  input  logic             wr_on,
  input  logic [LANES-1:0] be,
  input  logic             wide,
  input  logic             byte_wr,
  output logic             cs_n,
  output logic             rd_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_we_n,
  output logic             drive
);
  always_comb begin
    cs_n  = !(act && cs_on);
    rd_n  = !(act && rd_on && !is_wr);
    we_n  = !(act && wr_on && is_wr && !byte_wr);
    drive = act && is_wr;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_ok;
    assign lane_ok      = be[i] && ((i == 0) || wide);
    assign lane_n[i]    = !(act && cs_on && lane_ok && !byte_wr);
    assign lane_we_n[i] = !(act && wr_on && is_wr && byte_wr && lane_ok);
  end
endmodule

// File: rtl/emt_float.sv
module emt_float #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] count,
  output logic          zero
);
  logic [FW-1:0] cnt_q;
  logic [FW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? count : cnt_q - FW'(1);
    zero   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ext_mem_timing.sv
module ext_mem_timing #(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int LANES = DW / 8,
  parameter int SW    = 6,
  parameter int PW    = 7,
  parameter int CW    = 9,
  parameter int FW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LANES-1:0] req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ack,
  output logic [DW-1:0]    rd_data,
  input  logic [SW-1:0]    cfg_cs_rd_setup,
  input  logic [PW-1:0]    cfg_cs_rd_pulse,
  input  logic [SW-1:0]    cfg_rd_setup,
  input  logic [PW-1:0]    cfg_rd_pulse,
  input  logic [CW-1:0]    cfg_rd_cycle,
  input  logic [SW-1:0]    cfg_cs_wr_setup,
  input  logic [PW-1:0]    cfg_cs_wr_pulse,
  input  logic [SW-1:0]    cfg_wr_setup,
  input  logic [PW-1:0]    cfg_wr_pulse,
  input  logic [CW-1:0]    cfg_wr_cycle,
  input  logic [1:0]       cfg_wait_mode,
  input  logic             cfg_byte_write,
  input  logic             cfg_wide,
  input  logic [FW-1:0]    cfg_float_cycles,
  input  logic             cfg_float_skip,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cs_n,
  output logic             mem_rd_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_lane_n,
  output logic [LANES-1:0] mem_lane_we_n,
  input  logic             mem_wait_n,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_drive_en,
  input  logic [DW-1:0]    mem_din
);
  import emt_pkg::*;

  localparam int NS = NUM_STROBES;

  // reset: asserted asynchronously, released after two clock edges
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  // access state
  logic             busy_q, wr_q, ack_q;
  logic [CW-1:0]    cnt_q;
  logic [LANES-1:0] be_q;

  logic             start, finish, hold, adv, capture, float_zero;
  logic             nxt_busy, nxt_wr;
  logic [CW-1:0]    nxt_cnt, last_cur, last_nxt;
  logic [LANES-1:0] nxt_be;
  wait_mode_e       wmode;

  logic [SW-1:0] setup_cur [NS];
  logic [PW-1:0] pulse_cur [NS];
  logic [SW-1:0] setup_nxt [NS];
  logic [PW-1:0] pulse_nxt [NS];
  logic [NS-1:0] act_cur, end_cur, act_nxt, end_nxt;

  function automatic logic [CW-1:0] last_of(input logic [CW-1:0] len);
    return (len == '0) ? '0 : len - CW'(1);
  endfunction

  always_comb begin
    setup_cur[STROBE_CS] = wr_q ? cfg_cs_wr_setup : cfg_cs_rd_setup;
    pulse_cur[STROBE_CS] = wr_q ? cfg_cs_wr_pulse : cfg_cs_rd_pulse;
    setup_nxt[STROBE_CS] = nxt_wr ? cfg_cs_wr_setup : cfg_cs_rd_setup;
    pulse_nxt[STROBE_CS] = nxt_wr ? cfg_cs_wr_pulse : cfg_cs_rd_pulse;
    setup_cur[STROBE_RD] = cfg_rd_setup;
    pulse_cur[STROBE_RD] = cfg_rd_pulse;
    setup_nxt[STROBE_RD] = cfg_rd_setup;
    pulse_nxt[STROBE_RD] = cfg_rd_pulse;
    setup_cur[STROBE_WR] = cfg_wr_setup;
    pulse_cur[STROBE_WR] = cfg_wr_pulse;
    setup_nxt[STROBE_WR] = cfg_wr_setup;
    pulse_nxt[STROBE_WR] = cfg_wr_pulse;
  end

  for (genvar g = 0; g < NS; g++) begin : g_win
    emt_window #(.SW(SW), .PW(PW), .CW(CW)) u_cur (
      .cnt(cnt_q), .setup(setup_cur[g]), .pulse(pulse_cur[g]),
      .last(last_cur), .active(act_cur[g]), .at_end(end_cur[g]));
    emt_window #(.SW(SW), .PW(PW), .CW(CW)) u_nxt (
      .cnt(nxt_cnt), .setup(setup_nxt[g]), .pulse(pulse_nxt[g]),
      .last(last_nxt), .active(act_nxt[g]), .at_end(end_nxt[g]));
  end

  // next-state decode
  always_comb begin
    wmode    = wait_mode_e'(cfg_wait_mode);
    last_cur = last_of(wr_q ? cfg_wr_cycle : cfg_rd_cycle);
    start    = !busy_q && !ack_q && req_valid &&
               (float_zero || (cfg_float_skip && !req_write));
    hold     = busy_q && !mem_wait_n &&
               ((wmode == WAIT_FREEZE) ||
                ((wmode == WAIT_READY) &&
                 (wr_q ? end_cur[STROBE_WR] : end_cur[STROBE_RD])));
    finish   = busy_q && !hold && (cnt_q == last_cur);
    adv      = busy_q && !hold && !finish;
    capture  = busy_q && !hold && !wr_q && act_cur[STROBE_RD] && end_cur[STROBE_RD];
    nxt_busy = start || (busy_q && !finish);
    nxt_wr   = start ? req_write : wr_q;
    nxt_be   = start ? req_be : be_q;
    last_nxt = last_of(nxt_wr ? cfg_wr_cycle : cfg_rd_cycle);
    nxt_cnt  = start ? '0 : (adv ? cnt_q + CW'(1) : cnt_q);
  end

  logic             cs_n_d, rd_n_d, we_n_d, drive_d;
  logic [LANES-1:0] lane_n_d, lane_we_n_d;

  emt_lanes #(.LANES(LANES)) u_lanes (
    .act(nxt_busy), .is_wr(nxt_wr),
    .cs_on(act_nxt[STROBE_CS]), .rd_on(act_nxt[STROBE_RD]), .wr_on(act_nxt[STROBE_WR]),
    .be(nxt_be), .wide(cfg_wide), .byte_wr(cfg_byte_write),
    .cs_n(cs_n_d), .rd_n(rd_n_d), .we_n(we_n_d),
    .lane_n(lane_n_d), .lane_we_n(lane_we_n_d), .drive(drive_d));

  emt_float #(.FW(FW)) u_float (
    .clk(clk), .rst_n(rst_i), .load(finish && !wr_q),
    .count(cfg_float_cycles), .zero(float_zero));

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q        <= 1'b0;
      wr_q          <= 1'b0;
      ack_q         <= 1'b0;
      cnt_q         <= '0;
      be_q          <= '0;
      mem_cs_n      <= 1'b1;
      mem_rd_n      <= 1'b1;
      mem_we_n      <= 1'b1;
      mem_lane_n    <= '1;
      mem_lane_we_n <= '1;
      mem_drive_en  <= 1'b0;
    end else begin
      busy_q        <= nxt_busy;
      wr_q          <= nxt_wr;
      ack_q         <= finish;
      cnt_q         <= nxt_cnt;
      be_q          <= nxt_be;
      mem_cs_n      <= cs_n_d;
      mem_rd_n      <= rd_n_d;
      mem_we_n      <= we_n_d;
      mem_lane_n    <= lane_n_d;
      mem_lane_we_n <= lane_we_n_d;
      mem_drive_en  <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mem_addr <= '0;
      mem_dout <= '0;
    end else if (start) begin
      mem_addr <= req_addr;
      mem_dout <= cfg_wide ? req_wdata : {{(DW-8){1'b0}}, req_wdata[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)       rd_data <= '0;
    else if (capture) rd_data <= cfg_wide ? mem_din : {{(DW-8){1'b0}}, mem_din[7:0]};
  end

  assign req_ack = ack_q;
endmodule

// File: rtl/emt_checker.sv
module emt_checker #(
  parameter int LANES = 2,
  parameter int FW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ack,
  input logic             cs_n,
  input logic             rd_n,
  input logic             we_n,
  input logic [LANES-1:0] lane_n,
  input logic [LANES-1:0] lane_we_n,
  input logic             drive,
  input logic [1:0]       wait_mode,
  input logic             wait_n,
  input logic             wide,
  input logic             byte_wr,
  input logic             float_zero,
  input logic             float_skip
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && rd_n && we_n && (&lane_we_n)));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wait_mode == 2'd2 && !wait_n) |=> $stable({cs_n, rd_n, we_n, lane_n, lane_we_n}));

  p_bytewrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |-> (we_n && (&lane_n)));

  p_lane_narrow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (lane_n[LANES-1] && lane_we_n[LANES-1]));

  p_drive_no_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> rd_n);

  p_float_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !float_zero && !float_skip) |=> !busy);
endmodule

bind ext_mem_timing emt_checker #(.LANES(LANES), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_i), .busy(busy_q), .ack(req_ack),
  .cs_n(mem_cs_n), .rd_n(mem_rd_n), .we_n(mem_we_n),
  .lane_n(mem_lane_n), .lane_we_n(mem_lane_we_n), .drive(mem_drive_en),
  .wait_mode(cfg_wait_mode), .wait_n(mem_wait_n), .wide(cfg_wide),
  .byte_wr(cfg_byte_write), .float_zero(float_zero), .float_skip(cfg_float_skip));

// File: tb/ext_mem_timing_bench.sv
module ext_mem_timing_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rd_data;
  logic [5:0]  cs_rd_s = 0, rd_s = 0, cs_wr_s = 0, wr_s = 0;
  logic [6:0]  cs_rd_p = 1, rd_p = 1, cs_wr_p = 1, wr_p = 1;
  logic [8:0]  rd_c = 2, wr_c = 2;
  logic [1:0]  wmode = 0;
  logic        bw = 0, wide = 1, fskip = 0;
  logic [3:0]  fcyc = 0;
  logic [11:0] mem_addr;
  logic        mem_cs_n, mem_rd_n, mem_we_n, mem_drive_en;
  logic [1:0]  mem_lane_n, mem_lane_we_n;
  logic        mem_wait_n = 1;
  logic [15:0] mem_dout;
  logic [15:0] mem_din = '0;

  ext_mem_timing u_ext_mem_timing (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .rd_data(rd_data),
    .cfg_cs_rd_setup(cs_rd_s), .cfg_cs_rd_pulse(cs_rd_p),
    .cfg_rd_setup(rd_s), .cfg_rd_pulse(rd_p), .cfg_rd_cycle(rd_c),
    .cfg_cs_wr_setup(cs_wr_s), .cfg_cs_wr_pulse(cs_wr_p),
    .cfg_wr_setup(wr_s), .cfg_wr_pulse(wr_p), .cfg_wr_cycle(wr_c),
    .cfg_wait_mode(wmode), .cfg_byte_write(bw), .cfg_wide(wide),
    .cfg_float_cycles(fcyc), .cfg_float_skip(fskip),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_lane_we_n(mem_lane_we_n),
    .mem_wait_n(mem_wait_n), .mem_dout(mem_dout), .mem_drive_en(mem_drive_en),
    .mem_din(mem_din));

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit win(input int k, input int s, input int p);
    return (p != 0) && (k >= s) && (k < s + p);
  endfunction

  function automatic logic [8:0] outs();
    return {mem_cs_n, mem_rd_n, mem_we_n, mem_lane_n, mem_lane_we_n, mem_drive_en, req_ack};
  endfunction

  localparam logic [8:0] IDLE_V = 9'b111_11_11_0_0;

  // one access; k is the bench's own access cycle counter
  task automatic do_access(input bit wr, input logic [1:0] be, input logic [15:0] wd,
                           input int wait_at, input int wait_len);
    int scs, pcs, sd, pd, cyc, last, k, waited, cend, kcap;
    bit hold, lo, csb, rdb, wrb;
    logic [1:0] lane, lwe;
    logic [15:0] base, exp_rd;
    base = 16'hA500;
    scs = wr ? int'(cs_wr_s) : int'(cs_rd_s);
    pcs = wr ? int'(cs_wr_p) : int'(cs_rd_p);
    sd  = wr ? int'(wr_s) : int'(rd_s);
    pd  = wr ? int'(wr_p) : int'(rd_p);
    cyc = wr ? int'(wr_c) : int'(rd_c);
    if (cyc == 0) cyc = 1;
    last = cyc - 1;
    cend = ((sd + pd) < cyc ? (sd + pd) : cyc) - 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_be = be; req_wdata = wd;
    req_addr = wd[11:0]; mem_wait_n = 1; mem_din = base;
    @(negedge clk);
    k = 0; waited = 0;
    forever begin
      csb = win(k, scs, pcs);
      rdb = !wr && win(k, sd, pd);
      wrb = wr && win(k, sd, pd);
      for (int i = 0; i < 2; i++) begin
        lane[i] = !(csb && be[i] && (i == 0 || wide) && !bw);
        lwe[i]  = !(wrb && be[i] && (i == 0 || wide) && bw);
      end
      chk("R2 R3 R9 R10 R11 R12 strobes", {23'd0, outs()},
          {23'd0, !csb, !rdb, !(wrb && !bw), lane, lwe, wr, 1'b0});
      if (wr && k == 0) begin
        chk("R12 R11 write data", {16'd0, mem_dout}, {16'd0, wide ? wd : {8'h00, wd[7:0]}});
        chk("R12 address", {20'd0, mem_addr}, {20'd0, wd[11:0]});
      end
      mem_din = base + 16'(k);
      lo = (wait_len > 0) && (k == wait_at) && (waited < wait_len);
      if (lo) waited++;
      mem_wait_n = !lo;
      hold = lo && ((wmode == 2'd2) || (wmode == 2'd3 && k == cend && pd != 0));
      if (!hold && k == last) break;
      if (!hold) k++;
      @(negedge clk);
    end
    @(negedge clk);
    mem_wait_n = 1;
    req_valid = 0;
    chk("R4 ack cycle", {23'd0, outs()}, {23'd0, IDLE_V | 9'd1});
    if (!wr) begin
      kcap = ((sd + pd) < cyc ? (sd + pd) : cyc) - 1;
      exp_rd = base + 16'(kcap);
      if (!wide) exp_rd = {8'h00, exp_rd[7:0]};
      chk("R5 read data", {16'd0, rd_data}, {16'd0, exp_rd});
    end
  endtask

  // called at the ack falling edge; counts edges until chip select goes low
  task automatic gap(input bit wr, input int expect_n, input string tag);
    int n;
    req_valid = 1; req_write = wr; req_be = 2'b11; req_wdata = 16'h1234;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mem_cs_n && n < 60);
    chk(tag, n, expect_n);
    n = 0;
    while (!req_ack && n < 100) begin
      @(negedge clk);
      n++;
    end
    req_valid = 0;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {23'd0, outs()}, {23'd0, IDLE_V});
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 outputs after reset", {23'd0, outs()}, {23'd0, IDLE_V});

    // sweep of strobe timing, lane style and bus width
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 3; s++)
          for (int p = 1; p < 4; p++)
            for (int lg = 0; lg < 2; lg++) begin
              bw = b[0]; wide = w[0]; wmode = 0;
              rd_s = 6'(s); rd_p = 7'(p);
              rd_c = lg ? 9'(s + p + 1) : 9'(((s + p - 1) > s + 1) ? (s + p - 1) : (s + 1));
              cs_rd_s = 6'((s + 1) % 3); cs_rd_p = 7'(p + 1);
              wr_s = 6'(p - 1); wr_p = 7'(s + 1);
              wr_c = lg ? 9'(p + s + 2) : 9'(((p + s - 1) > p) ? (p + s - 1) : p);
              cs_wr_s = 0; cs_wr_p = 7'(s + p);
              do_access(1'b0, (2'(s + p + lg) == 2'b00) ? 2'b11 : 2'(s + p + lg), 16'h3C5A, 0, 0);
              do_access(1'b1, (2'(s + 2 * p + lg) == 2'b00) ? 2'b10 : 2'(s + 2 * p + lg),
                        16'(16'h9100 + s * 16 + p), 0, 0);
            end

    // wait behaviour on a fixed timing set
    bw = 0; wide = 1;
    cs_rd_s = 0; cs_rd_p = 6; rd_s = 1; rd_p = 3; rd_c = 6;
    cs_wr_s = 0; cs_wr_p = 5; wr_s = 1; wr_p = 2; wr_c = 5;
    wmode = 2;                          // R6 freeze
    do_access(1'b0, 2'b11, 16'h0001, 2, 4);
    do_access(1'b1, 2'b11, 16'h0F0F, 0, 3);
    wmode = 3;                          // R7 ready, at end of controlling pulse
    do_access(1'b0, 2'b11, 16'h0002, 3, 3);
    do_access(1'b1, 2'b01, 16'h0A0A, 2, 4);
    do_access(1'b0, 2'b11, 16'h0003, 1, 3);  // R7 wait away from pulse end has no effect
    wmode = 0;                          // R8 ignore
    do_access(1'b0, 2'b11, 16'h0004, 1, 4);
    wmode = 1;
    do_access(1'b1, 2'b11, 16'h0005, 2, 4);
    wmode = 0;

    // R4 zero cycle length counts as one
    rd_c = 0; cs_rd_p = 3; rd_s = 0; rd_p = 3;
    do_access(1'b0, 2'b11, 16'h0006, 0, 0);
    rd_c = 3; wr_c = 3; cs_rd_p = 2; cs_wr_p = 2; wr_s = 0;

    // R13 float interval
    fcyc = 5; fskip = 0;
    do_access(1'b0, 2'b11, 16'h0007, 0, 0);
    gap(1'b0, 6, "R13 float read after read");
    fskip = 1;
    do_access(1'b0, 2'b11, 16'h0008, 0, 0);
    gap(1'b0, 2, "R13 skip read after read");
    do_access(1'b0, 2'b11, 16'h0009, 0, 0);
    gap(1'b1, 6, "R13 write after read with skip");
    fskip = 0;
    do_access(1'b1, 2'b11, 16'h000A, 0, 0);
    gap(1'b0, 2, "R13 read after write");
    fcyc = 0;
    do_access(1'b0, 2'b11, 16'h000B, 0, 0);
    gap(1'b0, 2, "R13 zero float");

    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule